// File: doc/BRIEF.md
# USB Root Port Status and Control Register

This block holds the status and control word for a single root port of a USB host controller. Software reads and writes it as one 32-bit word over a simple register bus. Hardware inputs keep the connection, line-level and ownership fields current. The block does not drive the bus signalling itself. It provides the state that the port's signalling, reset-timing and test-pattern engines act on. Those engines read the stored fields and return events, such as the hardware enable pulse.

The connect input comes from the pad domain. It crosses into the register clock through a flop synchronizer before any change is detected. Every change of the current connect state latches a sticky change flag, which software clears by writing a 1 to it. Ownership of the port follows a configure flag. While that flag is low, the port belongs to the companion controller. Each rising edge of the flag hands the port back to this controller. While port power is off, the control fields that only make sense on a powered port read back as zero.

Top module: `usb_port_stsctl`

## Requirements
- R1: After reset the word reads 0x0000_2000: only the owner bit (bit 13) is 1, with both line inputs low.
- R2: Bits 31:20, bit 9 and bits 5:3 always read 0, whatever is written to them.
- R3: Bit 11 reflects `line_dp` and bit 10 reflects `line_dm`, with no clock delay.
- R4: Bit 0 (current connect) follows `conn_async` three rising clock edges after the input changes. Two of these edges are the synchronizer and one is the state register.
- R5: Bit 1 (connect change) is set in the same cycle that bit 0 changes. Writing 1 to bit 1 clears it. Writing 0 to bit 1 leaves it unchanged. A new change in the cycle of a clearing write leaves the bit set.
- R6: Bit 13 (owner) is held at 1 while `cfg_flag` is 0, and writes to it are then ignored. It is cleared on the clock edge that samples a 0-to-1 transition of `cfg_flag`. While `cfg_flag` is 1, bit 13 takes the written value.
- R7: Bit 2 (enable) is set by a `hw_enable` pulse only while bit 0 is 1. Software clears it by writing 0 to bit 2. Writing 1 to bit 2 does not set it. A disconnect clears it on the edge where bit 0 falls.
- R8: Bits 15:14 (indicator control) store written values when `INDICATOR_EN` is 1. When `INDICATOR_EN` is 0, writes to these bits are ignored and they read 0.
- R9: Bit 12 (power) and the written fields are read/write: bits 19:16 (test control), bit 8 (port reset), bit 7 (suspend) and bit 6 (force resume). `test_sel` outputs the test control value and `test_active` is 1 when that value is non-zero.
- R10: While bit 12 is 0, the following read as 0, and `test_sel` and `test_active` are 0: bits 19:16, bits 15:14, bits 8:6 and bit 2. The owner, power, line, change and connect bits still read their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr | input | 1 | Write strobe for the whole word |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, combinational from the current state |
| conn_async | input | 1 | Asynchronous device-present level from the port |
| line_dp | input | 1 | Current D+ line level |
| line_dm | input | 1 | Current D- line level |
| cfg_flag | input | 1 | Configure flag, synchronous to `clk` |
| hw_enable | input | 1 | One-cycle pulse from the reset sequencer enabling the port |
| test_sel | output | 4 | Selected test mode, 0 for normal operation |
| test_active | output | 1 | Port is in a test mode |

## Verification
The bench builds two instances side by side on the same inputs. One uses `INDICATOR_EN` = 1 and the other uses 0. Each written word is therefore seen stored in the indicator field by one instance and dropped by the other. Both instances keep the default two-stage synchronizer. This fixes the connect latency at three edges and lets the bench place a clearing write on exactly the edge where a new connect change lands.

// File: rtl/usb_port_pkg.sv
// Package usb_port_pkg
// Shared widths and bit positions of the port status/control word.
// Assumes one 32-bit word; positions are fixed because software decodes them.
package usb_port_pkg;
    localparam int CSR_W    = 32;
    localparam int PTC_W    = 4;
    localparam int PIC_W    = 2;

    localparam int B_CCS    = 0;
    localparam int B_CSC    = 1;
    localparam int B_PED    = 2;
    localparam int B_FPR    = 6;
    localparam int B_SUSP   = 7;
    localparam int B_PRST   = 8;
    localparam int B_LS_DM  = 10;
    localparam int B_LS_DP  = 11;
    localparam int B_PWR    = 12;
    localparam int B_OWN    = 13;
    localparam int B_PIC_LO = 14;
    localparam int B_PTC_LO = 16;

    // Plain software-written control fields of the port.
    typedef struct packed {
        logic [PTC_W-1:0] test_ctl;
        logic             pwr;
        logic             prst;
        logic             susp;
        logic             fres;
    } port_ctl_t;
endpackage

// File: rtl/usb_port_sync.sv
// Module usb_port_sync
// Multi-flop synchronizer for one asynchronous level.
// Assumes STAGES >= 2 and a slowly changing input (level, not pulse).
module usb_port_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the sampled level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/usb_port_conn_track.sv
// Module usb_port_conn_track
// Synchronizes the connect level, holds the current connect state and the
// sticky write-1-to-clear change flag. A change outranks a clearing write.
// Assumes csc_clr is a single-cycle request from the register write path.
module usb_port_conn_track #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conn_async,
    input  logic csc_clr,
    output logic ccs,
    output logic csc,
    output logic chg_evt,
    output logic disc_evt
);
    logic conn_s;

    usb_port_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (conn_async),
        .q     (conn_s)
    );

    assign chg_evt  = conn_s ^ ccs;
    assign disc_evt = chg_evt & ~conn_s;

    // Track the synchronized connect level.
    always_ff @(posedge clk) begin
        if (!rst_n) ccs <= 1'b0;
        else        ccs <= conn_s;
    end

    // Sticky change flag: set on a change, cleared by software otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       csc <= 1'b0;
        else if (chg_evt) csc <= 1'b1;
        else if (csc_clr) csc <= 1'b0;
    end
endmodule

// File: rtl/usb_port_owner.sv
// Module usb_port_owner
// Port owner bit: forced to 1 while the configure flag is low, cleared on
// the flag's rising edge, otherwise software-writable.
// Assumes cfg_flag is already synchronous to clk.
module usb_port_owner (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_flag,
    input  logic wr_en,
    input  logic wr_val,
    output logic owner
);
    logic cfg_q;

    // Remember the previous configure flag for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= 1'b0;
        else        cfg_q <= cfg_flag;
    end

    // Owner update with flag-low and flag-rise taking priority over writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                 owner <= 1'b1;
        else if (!cfg_flag)         owner <= 1'b1;
        else if (!cfg_q)            owner <= 1'b0;
        else if (wr_en)             owner <= wr_val;
    end
endmodule

// File: rtl/usb_port_stsctl.sv
// Module usb_port_stsctl
// Status and control register of one USB root port. Stores the control
// fields, combines them with live line levels and tracked connect state,
// and masks power-dependent fields to zero while port power is off.
// Assumes a single-word register: every write carries all fields.
module usb_port_stsctl
    import usb_port_pkg::*;
#(
    parameter bit INDICATOR_EN = 1'b1,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    input  logic             conn_async,
    input  logic             line_dp,
    input  logic             line_dm,
    input  logic             cfg_flag,
    input  logic             hw_enable,
    output logic [PTC_W-1:0] test_sel,
    output logic             test_active
);
    port_ctl_t        ctl_q;
    logic [PIC_W-1:0] pic_q;
    logic             ped_q;
    logic             ccs, csc, chg_evt, disc_evt;
    logic             owner;
    logic             ind_cap;

    assign ind_cap = INDICATOR_EN;

    usb_port_conn_track #(.SYNC_STAGES(SYNC_STAGES)) u_conn (
        .clk        (clk),
        .rst_n      (rst_n),
        .conn_async (conn_async),
        .csc_clr    (csr_wr & csr_wdata[B_CSC]),
        .ccs        (ccs),
        .csc        (csc),
        .chg_evt    (chg_evt),
        .disc_evt   (disc_evt)
    );

    usb_port_owner u_owner (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_flag (cfg_flag),
        .wr_en    (csr_wr),
        .wr_val   (csr_wdata[B_OWN]),
        .owner    (owner)
    );

    // Capture the plain read/write control fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (csr_wr) begin
            ctl_q.test_ctl <= csr_wdata[B_PTC_LO +: PTC_W];
            ctl_q.pwr      <= csr_wdata[B_PWR];
            ctl_q.prst     <= csr_wdata[B_PRST];
            ctl_q.susp     <= csr_wdata[B_SUSP];
            ctl_q.fres     <= csr_wdata[B_FPR];
        end
    end

    generate
        if (INDICATOR_EN) begin : g_pic
            // Store the indicator field when the capability is present.
            always_ff @(posedge clk) begin
                if (!rst_n)      pic_q <= '0;
                else if (csr_wr) pic_q <= csr_wdata[B_PIC_LO +: PIC_W];
            end
        end else begin : g_no_pic
            assign pic_q = '0;
        end
    endgenerate

    // Enable: disconnect clears, hardware sets when connected, software clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ped_q <= 1'b0;
        else if (disc_evt)                   ped_q <= 1'b0;
        else if (hw_enable && ccs)           ped_q <= 1'b1;
        else if (csr_wr && !csr_wdata[B_PED]) ped_q <= 1'b0;
    end

    // Assemble the read word with power masking.
    always_comb begin
        csr_rdata          = '0;
        csr_rdata[B_CCS]   = ccs;
        csr_rdata[B_CSC]   = csc;
        csr_rdata[B_LS_DM] = line_dm;
        csr_rdata[B_LS_DP] = line_dp;
        csr_rdata[B_PWR]   = ctl_q.pwr;
        csr_rdata[B_OWN]   = owner;
        if (ctl_q.pwr) begin
            csr_rdata[B_PED]                = ped_q;
            csr_rdata[B_FPR]                = ctl_q.fres;
            csr_rdata[B_SUSP]               = ctl_q.susp;
            csr_rdata[B_PRST]               = ctl_q.prst;
            csr_rdata[B_PIC_LO +: PIC_W]    = pic_q;
            csr_rdata[B_PTC_LO +: PTC_W]    = ctl_q.test_ctl;
        end
    end

    // Drive the test-mode selection seen by the test pattern engine.
    always_comb begin
        test_sel    = ctl_q.pwr ? ctl_q.test_ctl : '0;
        test_active = |test_sel;
    end
endmodule

// File: rtl/usb_port_stsctl_chk.sv
// Module usb_port_stsctl_chk
// Assertion checker bound into usb_port_stsctl; observes ports and a few
// internal signals driven by separate sub-blocks.
module usb_port_stsctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_wr,
    input logic [31:0] csr_wdata,
    input logic [31:0] csr_rdata,
    input logic        cfg_flag,
    input logic        chg_evt,
    input logic        ped_q,
    input logic [1:0]  pic_q,
    input logic        ind_cap
);
    // R6: owner reads 1 after any cycle with the configure flag low
    a_r6_owner_forced: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_flag |=> csr_rdata[13]);

    // R6: a rising configure flag hands ownership back
    a_r6_owner_handback: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_flag && !$past(cfg_flag)) |=> !csr_rdata[13]);

    // R5: any movement of the connect bit leaves the change flag set
    a_r5_change_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(csr_rdata[0]) |-> csr_rdata[1]);

    // R5: clearing write with no competing change clears the flag
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_wdata[1] && !chg_evt) |=> !csr_rdata[1]);

    // R7: enable cannot be held while disconnected
    a_r7_no_enable_disconnected: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rdata[0] |-> !ped_q);

    // R8: indicator storage stays empty without the capability
    a_r8_indicator_absent: assert property (@(posedge clk) disable iff (!rst_n)
        !ind_cap |-> (pic_q == 2'b00));
endmodule

bind usb_port_stsctl usb_port_stsctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wr    (csr_wr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .cfg_flag  (cfg_flag),
    .chg_evt   (chg_evt),
    .ped_q     (ped_q),
    .pic_q     (pic_q),
    .ind_cap   (ind_cap)
);

// File: tb/usb_port_stsctl_bench.sv
// Directed bench: two instances (indicator capability on and off) share inputs.
module usb_port_stsctl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic        conn_async = 1'b0;
    logic        line_dp = 1'b0;
    logic        line_dm = 1'b0;
    logic        cfg_flag = 1'b0;
    logic        hw_enable = 1'b0;
    logic [31:0] rd_a, rd_b;
    logic [3:0]  tsel_a, tsel_b;
    logic        tact_a, tact_b;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_port_stsctl #(.INDICATOR_EN(1'b1)) u_usb_port_stsctl (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(rd_a), .conn_async(conn_async), .line_dp(line_dp),
        .line_dm(line_dm), .cfg_flag(cfg_flag), .hw_enable(hw_enable),
        .test_sel(tsel_a), .test_active(tact_a));

    usb_port_stsctl #(.INDICATOR_EN(1'b0)) u_usb_port_stsctl_noind (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(rd_b), .conn_async(conn_async), .line_dp(line_dp),
        .line_dm(line_dm), .cfg_flag(cfg_flag), .hw_enable(hw_enable),
        .test_sel(tsel_b), .test_active(tact_b));

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [31:0] v);
        @(negedge clk);
        csr_wr = 1'b1;
        csr_wdata = v;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic hw_pulse();
        @(negedge clk);
        hw_enable = 1'b1;
        @(negedge clk);
        hw_enable = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset word", rd_a, 32'h0000_2000);
        check("R1 reset word noind", rd_b, 32'h0000_2000);
        check("R1 reset test_active", {31'b0, tact_a}, 32'h0);
    endtask

    task automatic t_line_levels();
        line_dp = 1'b1; line_dm = 1'b0; #1;
        check("R3 dp high", {30'b0, rd_a[11:10]}, 32'h2);
        line_dp = 1'b0; line_dm = 1'b1; #1;
        check("R3 dm high", {30'b0, rd_a[11:10]}, 32'h1);
        line_dm = 1'b0; #1;
    endtask

    task automatic t_fields();
        reg_write(32'hFFFF_FFFF);
        check("R2 R9 all-ones word", rd_a, 32'h000F_F1C0);
        check("R8 no indicator all-ones", rd_b, 32'h000F_31C0);
        check("R9 test_sel", {28'b0, tsel_a}, 32'hF);
        check("R9 test_active", {31'b0, tact_a}, 32'h1);
        reg_write(32'h0000_9000);
        check("R8 indicator stored", rd_a, 32'h0000_B000);
        check("R8 indicator ignored", rd_b, 32'h0000_3000);
        check("R9 test_active off", {31'b0, tact_a}, 32'h0);
    endtask

    task automatic t_power_mask();
        reg_write(32'h0000_1000);
        reg_write(32'hFFFF_EFFF);
        check("R10 power off masks", rd_a, 32'h0000_2000);
        check("R10 power off masks noind", rd_b, 32'h0000_2000);
        check("R10 test_sel masked", {27'b0, tact_a, tsel_a}, 32'h0);
        reg_write(32'hFFFF_FFFF);
        check("R10 power on shows fields", rd_a, 32'h000F_F1C0);
        reg_write(32'h0000_1000);
    endtask

    task automatic t_connect();
        conn_async = 1'b1;
        ticks(2);
        check("R4 connect not yet seen", {31'b0, rd_a[0]}, 32'h0);
        ticks(1);
        check("R4 connect seen", {31'b0, rd_a[0]}, 32'h1);
        check("R5 change set on connect", {31'b0, rd_a[1]}, 32'h1);
        reg_write(32'h0000_1000);
        check("R5 write zero keeps change", {31'b0, rd_a[1]}, 32'h1);
        reg_write(32'h0000_1002);
        check("R5 write one clears change", {31'b0, rd_a[1]}, 32'h0);
    endtask

    task automatic t_enable();
        hw_pulse();
        check("R7 hw sets enable", {31'b0, rd_a[2]}, 32'h1);
        reg_write(32'h0000_1004);
        check("R7 write one keeps enable", {31'b0, rd_a[2]}, 32'h1);
        reg_write(32'h0000_1000);
        check("R7 write zero clears enable", {31'b0, rd_a[2]}, 32'h0);
        reg_write(32'h0000_1004);
        check("R7 write one cannot set", {31'b0, rd_a[2]}, 32'h0);
        hw_pulse();
        check("R7 hw sets again", {31'b0, rd_a[2]}, 32'h1);
        conn_async = 1'b0;
        ticks(3);
        check("R4 disconnect seen", {31'b0, rd_a[0]}, 32'h0);
        check("R7 disconnect clears enable", {31'b0, rd_a[2]}, 32'h0);
        check("R5 change set on disconnect", {31'b0, rd_a[1]}, 32'h1);
        hw_pulse();
        check("R7 hw ignored when disconnected", {31'b0, rd_a[2]}, 32'h0);
    endtask

    task automatic t_set_wins();
        reg_write(32'h0000_1002);
        check("R5 cleared before race", {31'b0, rd_a[1]}, 32'h0);
        conn_async = 1'b1;
        ticks(1);
        reg_write(32'h0000_1002);
        check("R5 change wins over clear", {31'b0, rd_a[1]}, 32'h1);
        check("R4 connect after race", {31'b0, rd_a[0]}, 32'h1);
    endtask

    task automatic t_owner();
        reg_write(32'h0000_1000);
        check("R6 owner held while unconfigured", {31'b0, rd_a[13]}, 32'h1);
        cfg_flag = 1'b1;
        ticks(1);
        check("R6 owner cleared on flag rise", {31'b0, rd_a[13]}, 32'h0);
        reg_write(32'h0000_3000);
        check("R6 owner writable when configured", {31'b0, rd_a[13]}, 32'h1);
        cfg_flag = 1'b0;
        ticks(1);
        cfg_flag = 1'b1;
        ticks(1);
        check("R6 second flag rise clears", {31'b0, rd_a[13]}, 32'h0);
        cfg_flag = 1'b0;
        ticks(1);
        check("R6 owner back to 1", {31'b0, rd_a[13]}, 32'h1);
    endtask

    initial begin
        ticks(3);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_line_levels();
        t_fields();
        t_power_mask();
        t_connect();
        t_enable();
        t_set_wins();
        t_owner();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule